// File: doc/BRIEF.md
# Addressed Serial Channel Register Loader

This block is the digital receive side of a multi-channel converter. A host sends frames over three wires: an active-low frame sync, a serial clock and a serial data line. Each frame carries a channel address followed by a straight-binary code. The block collects the bits, decodes the address and stores the code in that channel's register. All channel registers are presented together on one wide parallel output that feeds the conversion logic.

The three serial wires are sampled by the block's own system clock through a synchronizer chain, and their edges are detected in that clock domain. Each serial clock level must therefore last at least a few system clock cycles. A falling sync edge arms the bit counter. After that, sync edges are ignored until the frame is complete. When the last bit arrives, a one-cycle update strobe fires with the channel index. Later serial clocks are then locked out until sync falls again.

Top module: `serial_chan_loader`

## Requirements
- R1: A frame is ADDR_W+DATA_W bits (5+14 = 19 by default). The first bit received is the address MSB. The address bits come first, MSB first, then the code bits, MSB first. The last bit received is the code LSB.
- R2: The code is written only into the register the address selects. Every other channel register keeps its value.
- R3: Data is taken on falling edges of the serial clock only. Rising edges shift nothing.
- R4: A falling sync edge while no frame is in progress clears the bit counter and arms reception. Sync edges that occur while a frame is in progress are ignored. The bits already collected are kept and the count continues.
- R5: Once the final bit of a frame has arrived, further serial clock edges are ignored until sync falls again.
- R6: The write happens once per frame, at the final falling clock edge. At that edge, `upd_stb` pulses high for exactly one system clock cycle and `upd_idx` carries the channel address.
- R7: Driving `rst_n` low asynchronously clears every channel register, the shift register and the bit counter, and disarms reception. A partial frame in progress is lost.
- R8: Codes are stored unchanged as straight binary, from 0 to 2^DATA_W-1. Channel k appears on `ch_codes[k*DATA_W +: DATA_W]`.
- R9: Serial clock edges that arrive before any sync fall, with sync high, are ignored. A free-running serial clock and a gated one therefore both work.
- R10: After power-on reset, every channel register reads zero and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial wires |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sync_n | input | 1 | Active-low frame sync |
| ser_clk | input | 1 | Serial clock; data taken on its falling edge |
| ser_din | input | 1 | Serial data, address MSB first |
| ch_codes | output | NUM_CH*DATA_W | All channel registers, channel k at bits k*DATA_W upward |
| upd_stb | output | 1 | One-cycle pulse when a channel register is written |
| upd_idx | output | ADDR_W | Channel index written, valid with upd_stb |

## Verification
The bench builds the block with its default parameters: 32 channels, 14-bit codes and a two-stage synchronizer. With these values the address space is exactly full, so the lowest and highest channels can both be reached, and the codes 0 and 16383 test the ends of the straight-binary range. The default frame length of 19 bits allows a frame to be split across a spurious sync pulse at bit 10. It also allows a lockout burst to be sent right after the 19th edge.

// File: rtl/scl_pkg.sv
package scl_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_DONE  = 2'd2
    } rx_state_e;

endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES:0] pipe_d;
            logic [STAGES:0] pipe_q;

            always_comb begin
                pipe_d = {pipe_q[STAGES-1:0], async_i[b]};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe_q <= {(STAGES+1){RST_VAL[b]}};
                end else begin
                    pipe_q <= pipe_d;
                end
            end

            assign sync_o[b] = pipe_q[STAGES-1];
            assign prev_o[b] = pipe_q[STAGES];
        end
    endgenerate

endmodule

// File: rtl/scl_frame_rx.sv
module scl_frame_rx
    import scl_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 14,
    localparam int FRAME_W = ADDR_W + DATA_W,
    localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_fall_i,
    input  logic              sync_fall_i,
    input  logic              din_i,
    output logic              stb_o,
    output logic [ADDR_W-1:0] idx_o,
    output logic [DATA_W-1:0] code_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        rx_state_e          state;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-2:0] shreg;
        logic               stb;
        logic [ADDR_W-1:0]  idx;
        logic [DATA_W-1:0]  code;
    } rx_regs_t;

    rx_regs_t           rx_d;
    rx_regs_t           rx_q;
    logic [FRAME_W-1:0] word_full;

    always_comb begin
        rx_d      = rx_q;
        rx_d.stb  = 1'b0;
        word_full = {rx_q.shreg, din_i};
        case (rx_q.state)
            RX_IDLE, RX_DONE: begin
                if (sync_fall_i) begin
                    rx_d.state = RX_SHIFT;
                    rx_d.cnt   = '0;
                    rx_d.shreg = '0;
                end
            end
            RX_SHIFT: begin
                if (sclk_fall_i) begin
                    rx_d.shreg = word_full[FRAME_W-2:0];
                    rx_d.cnt   = rx_q.cnt + 1'b1;
                    if (rx_q.cnt == LAST) begin
                        rx_d.stb   = 1'b1;
                        rx_d.idx   = word_full[FRAME_W-1 -: ADDR_W];
                        rx_d.code  = word_full[DATA_W-1:0];
                        rx_d.state = RX_DONE;
                    end
                end
            end
            default: rx_d.state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '{state: RX_IDLE, cnt: '0, shreg: '0, stb: 1'b0,
                      idx: '0, code: '0};
        end else begin
            rx_q <= rx_d;
        end
    end

    assign stb_o  = rx_q.stb;
    assign idx_o  = rx_q.idx;
    assign code_o = rx_q.code;

    // R6: the update strobe never lasts two cycles
    assert_stb_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.stb |=> !rx_q.stb);

    // R5: a finished frame produces no further strobe without re-arming
    assert_lockout_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.state == RX_DONE) |=> !rx_q.stb);

    // R4: a sync fall without a clock edge during a frame leaves the count alone
    assert_sync_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.state == RX_SHIFT && sync_fall_i && !sclk_fall_i) |=> $stable(rx_q.cnt));

    // R9: clock edges seen while disarmed do not start a count
    assert_idle_clk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.state == RX_IDLE && !sync_fall_i) |=> (rx_q.state == RX_IDLE));

endmodule

// File: rtl/scl_chan_bank.sv
module scl_chan_bank #(
    parameter int NUM_CH = 32,
    parameter int DATA_W = 14,
    localparam int ADDR_W = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stb_i,
    input  logic [ADDR_W-1:0]        idx_i,
    input  logic [DATA_W-1:0]        code_i,
    output logic [NUM_CH*DATA_W-1:0] codes_o
);

    logic [DATA_W-1:0] regs_d [NUM_CH];
    logic [DATA_W-1:0] regs_q [NUM_CH];

    always_comb begin
        for (int k = 0; k < NUM_CH; k++) begin
            if (stb_i && (idx_i == ADDR_W'(k))) begin
                regs_d[k] = code_i;
            end else begin
                regs_d[k] = regs_q[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_CH; k++) begin
                regs_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < NUM_CH; k++) begin
                regs_q[k] <= regs_d[k];
            end
        end
    end

    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_out
            assign codes_o[k*DATA_W +: DATA_W] = regs_q[k];

            // R2: the addressed channel takes the strobed code
            assert_write_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (stb_i && idx_i == ADDR_W'(k)) |=> (regs_q[k] == $past(code_i)));

            // R2: a channel that is not addressed keeps its value
            assert_write_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !(stb_i && idx_i == ADDR_W'(k)) |=> $stable(regs_q[k]));
        end
    endgenerate

endmodule

// File: rtl/serial_chan_loader.sv
module serial_chan_loader #(
    parameter int NUM_CH      = 32,
    parameter int DATA_W      = 14,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_sync_n,
    input  logic                     ser_clk,
    input  logic                     ser_din,
    output logic [NUM_CH*DATA_W-1:0] ch_codes,
    output logic                     upd_stb,
    output logic [ADDR_W-1:0]        upd_idx
);

    // bit 2: sync (idles high), bit 1: serial clock, bit 0: data
    logic [2:0] pins_s;
    logic [2:0] pins_p;
    logic       sclk_fall;
    logic       sync_fall;
    logic       rx_stb;
    logic [ADDR_W-1:0] rx_idx;
    logic [DATA_W-1:0] rx_code;

    scl_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_sync_n, ser_clk, ser_din}),
        .sync_o  (pins_s),
        .prev_o  (pins_p)
    );

    assign sclk_fall = pins_p[1] & ~pins_s[1];
    assign sync_fall = pins_p[2] & ~pins_s[2];

    scl_frame_rx #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_fall_i (sclk_fall),
        .sync_fall_i (sync_fall),
        .din_i       (pins_s[0]),
        .stb_o       (rx_stb),
        .idx_o       (rx_idx),
        .code_o      (rx_code)
    );

    scl_chan_bank #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_i   (rx_stb),
        .idx_i   (rx_idx),
        .code_i  (rx_code),
        .codes_o (ch_codes)
    );

    assign upd_stb = rx_stb;
    assign upd_idx = rx_idx;

endmodule

// File: tb/tb_serial_chan_loader.sv
module tb_serial_chan_loader;

    localparam int NUM_CH  = 32;
    localparam int DATA_W  = 14;
    localparam int ADDR_W  = 5;
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int BUSW    = NUM_CH * DATA_W;
    localparam int HALF    = 4;
    localparam int NVEC    = 8;

    // frame words: {address, code}
    localparam logic [FRAME_W-1:0] VEC [NVEC] = '{
        {5'd0,  14'h0001},
        {5'd31, 14'h3FFF},
        {5'd5,  14'h2AAA},
        {5'd17, 14'h1555},
        {5'd31, 14'h0000},
        {5'd8,  14'h2001},
        {5'd0,  14'h3FFE},
        {5'd22, 14'h0F0F}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_sync_n = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_din = 1'b0;
    logic [BUSW-1:0]   ch_codes;
    logic              upd_stb;
    logic [ADDR_W-1:0] upd_idx;

    int errors = 0;
    int checks = 0;
    int stb_cnt = 0;
    logic [ADDR_W-1:0] last_idx = '0;
    logic finished = 1'b0;
    logic [DATA_W-1:0] model [NUM_CH];

    always #2 clk = ~clk;

    serial_chan_loader #(
        .NUM_CH (NUM_CH), .DATA_W (DATA_W), .SYNC_STAGES (2)
    ) dut (
        .clk (clk), .rst_n (rst_n), .ser_sync_n (ser_sync_n),
        .ser_clk (ser_clk), .ser_din (ser_din),
        .ch_codes (ch_codes), .upd_stb (upd_stb), .upd_idx (upd_idx)
    );

    always @(posedge clk) begin
        if (upd_stb) begin
            stb_cnt  <= stb_cnt + 1;
            last_idx <= upd_idx;
        end
    end

    function automatic logic [BUSW-1:0] packed_model();
        logic [BUSW-1:0] v;
        for (int k = 0; k < NUM_CH; k++) v[k*DATA_W +: DATA_W] = model[k];
        return v;
    endfunction

    task automatic chk(input string tag, input logic [BUSW-1:0] act,
                       input logic [BUSW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sync_fall();
        ser_sync_n = 1'b1; wait_clk(HALF);
        ser_sync_n = 1'b0; wait_clk(HALF);
    endtask

    task automatic send_bits(input logic [FRAME_W-1:0] w, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) begin
            ser_din = w[i];
            ser_clk = 1'b1; wait_clk(HALF);
            ser_clk = 1'b0; wait_clk(HALF);
        end
    endtask

    task automatic frame(input logic [FRAME_W-1:0] w);
        sync_fall();
        send_bits(w, FRAME_W-1, 0);
        wait_clk(8);
        ser_sync_n = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic model_write(input logic [FRAME_W-1:0] w);
        model[w[FRAME_W-1 -: ADDR_W]] = w[DATA_W-1:0];
    endtask

    initial begin
        int base;
        logic [FRAME_W-1:0] w;
        for (int k = 0; k < NUM_CH; k++) model[k] = '0;
        wait_clk(5);
        // R10: reset state
        chk("R10 codes zero in reset", ch_codes, '0);
        rst_n = 1'b1;
        wait_clk(10);
        chk("R10 codes zero after reset", ch_codes, '0);
        chk("R10 no strobe after reset", BUSW'(stb_cnt), '0);

        // R1 R2 R6 R8: vector walk
        for (int v = 0; v < NVEC; v++) begin
            base = stb_cnt;
            frame(VEC[v]);
            model_write(VEC[v]);
            chk("R1/R2/R8 channel bus after frame", ch_codes, packed_model());
            chk("R6 one strobe per frame", BUSW'(stb_cnt - base), BUSW'(1));
            chk("R6 strobe index", BUSW'(last_idx), BUSW'(VEC[v][FRAME_W-1 -: ADDR_W]));
        end

        // R3 R5: lockout after final bit, sync held low
        base = stb_cnt;
        w = {5'd3, 14'h1234};
        sync_fall();
        send_bits(w, FRAME_W-1, 0);
        model_write(w);
        send_bits({5'd3, 14'h3333}, 5, 0);
        wait_clk(8);
        chk("R5 extra clocks ignored, code kept", ch_codes, packed_model());
        chk("R5 no extra strobe", BUSW'(stb_cnt - base), BUSW'(1));
        ser_sync_n = 1'b1; wait_clk(HALF);

        // R9: free clock with sync high before arming
        base = stb_cnt;
        send_bits({FRAME_W{1'b1}}, 6, 0);
        wait_clk(8);
        chk("R9 clocks without sync write nothing", BUSW'(stb_cnt - base), '0);
        w = {5'd12, 14'h0ABC};
        frame(w);
        model_write(w);
        chk("R9 frame after free clock", ch_codes, packed_model());

        // R4: sync pulse in mid frame is ignored, bits stitched
        base = stb_cnt;
        w = {5'd9, 14'h2C3D};
        sync_fall();
        send_bits(w, FRAME_W-1, 9);
        wait_clk(8);
        chk("R4 no strobe on partial frame", BUSW'(stb_cnt - base), '0);
        sync_fall();
        send_bits(w, 8, 0);
        wait_clk(8);
        model_write(w);
        chk("R4 stitched frame written", ch_codes, packed_model());
        chk("R4 single strobe for stitched frame", BUSW'(stb_cnt - base), BUSW'(1));
        ser_sync_n = 1'b1; wait_clk(HALF);

        // R7: reset during a partial frame
        sync_fall();
        send_bits({5'd4, 14'h1111}, FRAME_W-1, 10);
        @(negedge clk); rst_n = 1'b0;
        for (int k = 0; k < NUM_CH; k++) model[k] = '0;
        wait_clk(3);
        chk("R7 reset clears all channels", ch_codes, '0);
        rst_n = 1'b1;
        ser_sync_n = 1'b1;
        wait_clk(6);
        base = stb_cnt;
        send_bits({5'd4, 14'h1111}, 8, 0);
        wait_clk(8);
        chk("R7 counter disarmed by reset", BUSW'(stb_cnt - base), '0);
        w = {5'd30, 14'h3C01};
        frame(w);
        model_write(w);
        chk("R7 clean frame after reset", ch_codes, packed_model());

        // R3: rising edges alone shift nothing
        base = stb_cnt;
        sync_fall();
        ser_clk = 1'b1; wait_clk(HALF * 4);
        w = {5'd1, 14'h0077};
        send_bits(w, FRAME_W-1, 0);
        wait_clk(8);
        model_write(w);
        chk("R3 falling edges only", ch_codes, packed_model());
        ser_sync_n = 1'b1;
        wait_clk(HALF);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule